// File: doc/BRIEF.md
# Cascaded Interrupt Acknowledge and Vector Unit

This block holds the request, stored-level, in-service and priority-offset state of two chained eight-line interrupt controllers. One is the primary controller; the other is the secondary controller, which feeds it through one cascade line. Each of the sixteen request inputs is captured either on a rising edge or by its level, as chosen by a trigger-mode register. Each controller resolves its pending requests by rotating priority against its in-service lines. The primary controller's result drives a single interrupt output toward the processor.

When the processor pulses the acknowledge strobe, the block decides which controller supplies the vector. It updates in-service, request and rotation state as configured, and one clock later presents an 8-bit vector number with a one-cycle valid flag. Base vectors and the auto-EOI and rotate-on-auto-EOI settings for each controller arrive as static inputs. Register programming is handled elsewhere.

Top module: `pic_cascade_ack`

## Requirements
- R1: A line in level mode has a request bit equal to its input level as sampled at the previous clock edge, so dropping the input withdraws the request.
- R2: A line in edge mode becomes pending only when its sampled input goes from 0 to 1. An input held high after acknowledge raises no new request. A fall followed by a rise raises one.
- R3: On acknowledge, the winning line's request bit is cleared only if that line is in edge mode. A level-mode line stays pending while its input is high.
- R4: With auto-EOI off, acknowledge marks the line in service. Later requests of the same or lower priority are held off, and a request of higher priority still raises the interrupt output.
- R5: With auto-EOI and rotate-on-auto-EOI both on, acknowledging line L sets that controller's priority offset to (L+1) mod 8, so line L becomes the lowest priority. At reset the offset is 0, so line 0 has the highest priority.
- R6: Among several pending lines with no rotation applied, the lowest-numbered line is acknowledged first.
- R7: The secondary controller's interrupt request drives primary line 2, and request input bit 2 is unused. When primary line 2 wins, the secondary winner is acknowledged and the vector is the secondary base with bits [2:0] replaced by the secondary line.
- R8: When primary line 2 wins but the secondary has no winner, the vector is the secondary base with bits [2:0] = 7. Primary line 2 is still acknowledged.
- R9: An acknowledge while the primary has no winner returns the primary base with bits [2:0] = 7 and changes no state.
- R10: A trigger-mode write stores the write data ANDed with a per-bit writable mask (bits 7:0 primary, 15:8 secondary, 1 = level). Reset clears the register to all-edge. Defaults: primary 0xF8, secondary 0xDE.
- R11: The vector and its valid flag appear in the cycle after the acknowledge strobe, and valid is high for exactly that one cycle. Base bits [2:0] are ignored.
- R12: The interrupt output is high exactly when the primary controller has a request of higher priority than all of its in-service lines.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_in | input | 16 | Request lines; 7:0 primary, 15:8 secondary |
| trig_we | input | 1 | Trigger-mode register write strobe |
| trig_wdata | input | 16 | Trigger-mode write data, 1 = level mode |
| ack | input | 1 | Single-cycle processor acknowledge strobe |
| m_base | input | 8 | Primary base vector, bits 7:3 used |
| s_base | input | 8 | Secondary base vector, bits 7:3 used |
| m_aeoi | input | 1 | Primary auto-EOI enable |
| m_rot_aeoi | input | 1 | Primary rotate-on-auto-EOI enable |
| s_aeoi | input | 1 | Secondary auto-EOI enable |
| s_rot_aeoi | input | 1 | Secondary rotate-on-auto-EOI enable |
| vector | output | 8 | Acknowledged vector number |
| vec_valid | output | 1 | Vector valid, one cycle |
| int_out | output | 1 | Combined interrupt request to the processor |

## Verification
The bound checker enforces some rules on every cycle: the acknowledge-to-valid timing and the one-cycle valid pulse, the base-plus-7 vector on an acknowledge with no pending request, and the trigger register holding its value between writes. Priority ordering, rotation, in-service blocking and the edge-versus-level clearing rules depend on the history of requests. The bench covers these through scenarios, comparing against a behavioural model every clock. The model also shows the extra cycle that the cascade adds before a secondary request reaches the interrupt output.

// File: rtl/pic_cascade_pkg.sv
package pic_cascade_pkg;
    localparam int PIC_LINES = 8;
    localparam int PIC_LW    = $clog2(PIC_LINES);

    typedef struct packed {
        logic [PIC_LINES-1:0] irr;
        logic [PIC_LINES-1:0] prev;
        logic [PIC_LINES-1:0] isr;
        logic [PIC_LW-1:0]    offset;
    } bank_state_t;

    typedef struct packed {
        logic [2*PIC_LINES-1:0] trig;
        logic [7:0]             vec;
        logic                   vld;
    } top_state_t;
endpackage

// File: rtl/pic_prio_resolver.sv
module pic_prio_resolver
    import pic_cascade_pkg::*;
#(
    parameter int NL = PIC_LINES,
    localparam int LW = $clog2(NL)
) (
    input  logic [NL-1:0] req,
    input  logic [NL-1:0] busy,
    input  logic [LW-1:0] offset,
    output logic          hit,
    output logic [LW-1:0] line
);
    logic [LW:0]   req_rank;
    logic [LW:0]   busy_rank;
    logic [LW-1:0] idx;

    // rank = distance from the offset; scanning downward keeps the smallest
    always_comb begin
        req_rank  = (LW+1)'(NL);
        busy_rank = (LW+1)'(NL);
        idx       = '0;
        for (int p = NL - 1; p >= 0; p--) begin
            idx = LW'(p) + offset;
            if (req[idx])  req_rank  = (LW+1)'(p);
            if (busy[idx]) busy_rank = (LW+1)'(p);
        end
        hit  = (req_rank < busy_rank);
        line = req_rank[LW-1:0] + offset;
    end
endmodule

// File: rtl/pic_bank.sv
module pic_bank
    import pic_cascade_pkg::*;
#(
    parameter int NL = PIC_LINES,
    localparam int LW = $clog2(NL)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [NL-1:0] lvl,
    input  logic [NL-1:0] level_mode,
    input  logic          ack_en,
    input  logic [LW-1:0] ack_line,
    input  logic          aeoi,
    input  logic          rot_aeoi,
    output logic          hit,
    output logic [LW-1:0] line
);
    bank_state_t st_d, st_q;

    pic_prio_resolver #(.NL(NL)) u_res (
        .req    (st_q.irr),
        .busy   (st_q.isr),
        .offset (st_q.offset),
        .hit    (hit),
        .line   (line)
    );

    always_comb begin
        st_d = st_q;
        if (ack_en) begin
            if (aeoi) begin
                if (rot_aeoi) st_d.offset = ack_line + LW'(1);
            end else begin
                st_d.isr[ack_line] = 1'b1;
            end
            if (!level_mode[ack_line]) st_d.irr[ack_line] = 1'b0;
        end
        for (int i = 0; i < NL; i++) begin
            if (level_mode[i]) begin
                st_d.irr[i] = lvl[i];
            end else if (lvl[i] && !st_q.prev[i]) begin
                st_d.irr[i] = 1'b1;
            end
            st_d.prev[i] = lvl[i];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/pic_cascade_ack.sv
module pic_cascade_ack
    import pic_cascade_pkg::*;
#(
    parameter logic [PIC_LINES-1:0] MASTER_TRIG_MASK = 8'hF8,
    parameter logic [PIC_LINES-1:0] SLAVE_TRIG_MASK  = 8'hDE,
    parameter int                   CASCADE_LINE     = 2
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [15:0] irq_in,
    input  logic        trig_we,
    input  logic [15:0] trig_wdata,
    input  logic        ack,
    input  logic [7:0]  m_base,
    input  logic [7:0]  s_base,
    input  logic        m_aeoi,
    input  logic        m_rot_aeoi,
    input  logic        s_aeoi,
    input  logic        s_rot_aeoi,
    output logic [7:0]  vector,
    output logic        vec_valid,
    output logic        int_out
);
    localparam int NL = PIC_LINES;
    localparam int LW = PIC_LW;
    localparam logic [2*NL-1:0] TRIG_MASK = {SLAVE_TRIG_MASK, MASTER_TRIG_MASK};
    localparam logic [LW-1:0]   CASC      = LW'(CASCADE_LINE);
    localparam logic [7:0]      BASE_KEEP = ~8'(NL - 1);

    top_state_t    t_d, t_q;
    logic          m_hit, s_hit;
    logic [LW-1:0] m_line, s_line;
    logic [NL-1:0] m_lvl;
    logic          m_ack, s_ack, casc_win;

    always_comb begin
        m_lvl       = irq_in[NL-1:0];
        m_lvl[CASC] = s_hit;
    end

    assign casc_win = m_hit && (m_line == CASC);
    assign m_ack    = ack && m_hit;
    assign s_ack    = ack && casc_win && s_hit;

    pic_bank #(.NL(NL)) u_master (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (m_lvl),
        .level_mode (t_q.trig[NL-1:0]),
        .ack_en     (m_ack),
        .ack_line   (m_line),
        .aeoi       (m_aeoi),
        .rot_aeoi   (m_rot_aeoi),
        .hit        (m_hit),
        .line       (m_line)
    );

    pic_bank #(.NL(NL)) u_slave (
        .clk        (clk),
        .rst_n      (rst_n),
        .lvl        (irq_in[2*NL-1:NL]),
        .level_mode (t_q.trig[2*NL-1:NL]),
        .ack_en     (s_ack),
        .ack_line   (s_line),
        .aeoi       (s_aeoi),
        .rot_aeoi   (s_rot_aeoi),
        .hit        (s_hit),
        .line       (s_line)
    );

    always_comb begin
        t_d     = t_q;
        t_d.vld = ack;
        if (trig_we) t_d.trig = trig_wdata & TRIG_MASK;
        if (ack) begin
            if (!m_hit) begin
                t_d.vec = (m_base & BASE_KEEP) | 8'(NL - 1);
            end else if (casc_win) begin
                t_d.vec = (s_base & BASE_KEEP) | (s_hit ? 8'(s_line) : 8'(NL - 1));
            end else begin
                t_d.vec = (m_base & BASE_KEEP) | 8'(m_line);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign vector    = t_q.vec;
    assign vec_valid = t_q.vld;
    assign int_out   = m_hit;
endmodule

// File: rtl/pic_cascade_ack_chk.sv
module pic_cascade_ack_chk #(
    parameter logic [15:0] MASK = 16'hDEF8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        ack,
    input logic        int_out,
    input logic        vec_valid,
    input logic [7:0]  vector,
    input logic [7:0]  m_base,
    input logic        trig_we,
    input logic [15:0] trig_q
);
    // R11
    ack_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ack |=> vec_valid);
    // R11
    valid_only_after_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !ack |=> !vec_valid);
    // R9
    spurious_master_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !int_out) |=> (vector == {$past(m_base[7:3]), 3'd7}));
    // R10
    trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !trig_we |=> $stable(trig_q));
    // R10
    trig_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        trig_we |=> ((trig_q & ~MASK) == 16'h0));
endmodule

bind pic_cascade_ack pic_cascade_ack_chk #(.MASK(TRIG_MASK)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ack       (ack),
    .int_out   (int_out),
    .vec_valid (vec_valid),
    .vector    (vector),
    .m_base    (m_base),
    .trig_we   (trig_we),
    .trig_q    (t_q.trig)
);

// File: tb/pic_cascade_ack_tb_top.sv
module pic_cascade_ack_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam logic [15:0] MASK = 16'hDEF8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] irq = '0;
    logic        trig_we = 1'b0;
    logic [15:0] trig_wdata = '0;
    logic        ack = 1'b0;
    logic [7:0]  m_base = 8'h0D;
    logic [7:0]  s_base = 8'h73;
    logic        m_aeoi = 1'b1, m_rot = 1'b0, s_aeoi = 1'b1, s_rot = 1'b0;
    logic [7:0]  vector;
    logic        vec_valid, int_out;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    // behavioural reference state
    logic [7:0]  r_irr[2], r_last[2], r_isr[2];
    int          r_off[2];
    logic [15:0] r_trig;
    logic        r_vv;
    logic [7:0]  r_vec;

    always #(CLK_PERIOD/2) clk = ~clk;

    pic_cascade_ack dut_i (
        .clk(clk), .rst_n(rst_n), .irq_in(irq), .trig_we(trig_we),
        .trig_wdata(trig_wdata), .ack(ack), .m_base(m_base), .s_base(s_base),
        .m_aeoi(m_aeoi), .m_rot_aeoi(m_rot), .s_aeoi(s_aeoi), .s_rot_aeoi(s_rot),
        .vector(vector), .vec_valid(vec_valid), .int_out(int_out)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic int winner(int c);
        int rp = 8, ip = 8;
        for (int p = 0; p < 8; p++) begin
            int l = (p + r_off[c]) % 8;
            if (rp == 8 && r_irr[c][l]) rp = p;
            if (ip == 8 && r_isr[c][l]) ip = p;
        end
        return (rp < ip) ? (rp + r_off[c]) % 8 : -1;
    endfunction

    task automatic model_ack(int c, int l, bit ae, bit ro);
        if (ae) begin
            if (ro) r_off[c] = (l + 1) % 8;
        end else r_isr[c][l] = 1'b1;
        if (!r_trig[c*8+l]) r_irr[c][l] = 1'b0;
    endtask

    task automatic model_reset();
        for (int c = 0; c < 2; c++) begin
            r_irr[c] = '0; r_last[c] = '0; r_isr[c] = '0; r_off[c] = 0;
        end
        r_trig = '0; r_vv = 1'b0; r_vec = '0;
    endtask

    task automatic model_clock();
        int ws = winner(1);
        int wm = winner(0);
        logic [7:0] nvec = r_vec;
        if (ack) begin
            if (wm < 0) nvec = (m_base & 8'hF8) + 8'd7;
            else if (wm == 2) begin
                if (ws >= 0) begin
                    nvec = (s_base & 8'hF8) + 8'(ws);
                    model_ack(1, ws, s_aeoi, s_rot);
                end else nvec = (s_base & 8'hF8) + 8'd7;
                model_ack(0, 2, m_aeoi, m_rot);
            end else begin
                nvec = (m_base & 8'hF8) + 8'(wm);
                model_ack(0, wm, m_aeoi, m_rot);
            end
        end
        for (int c = 0; c < 2; c++) begin
            for (int l = 0; l < 8; l++) begin
                bit lv = (c == 0 && l == 2) ? (ws >= 0) : irq[c*8+l];
                if (r_trig[c*8+l]) r_irr[c][l] = lv;
                else if (lv && !r_last[c][l]) r_irr[c][l] = 1'b1;
                r_last[c][l] = lv;
            end
        end
        if (trig_we) r_trig = trig_wdata & MASK;
        r_vv  = ack;
        r_vec = nvec;
    endtask

    task automatic compare();
        chk(vec_valid == r_vv, "R11 valid", vec_valid, r_vv);
        if (r_vv) chk(vector == r_vec, "R11 vector", vector, r_vec);
        chk(int_out == (winner(0) >= 0), "R12 int_out", int_out, winner(0) >= 0);
    endtask

    task automatic step();
        model_clock();
        @(posedge clk);
        @(negedge clk);
        compare();
    endtask

    task automatic do_ack(output logic [7:0] v);
        ack = 1'b1;
        step();
        ack = 1'b0;
        v = vector;
    endtask

    task automatic do_reset();
        rst_n = 1'b0; irq = '0; ack = 1'b0; trig_we = 1'b0;
        model_reset();
        @(posedge clk); @(posedge clk); @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000) begin
            errors++;
            $display("FAIL watchdog R11 actual=%0d expected=%0d", cycles, 100000);
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] v;
        do_reset();
        chk(vec_valid == 1'b0 && int_out == 1'b0 && vector == 8'h00, "R11 reset",
            {vec_valid, int_out, vector}, 0);

        // R6 fixed order, R9 spurious, R11 base low bits dropped
        irq[3] = 1; irq[5] = 1; step();
        do_ack(v); chk(v == 8'h0B, "R6 first", v, 8'h0B);
        do_ack(v); chk(v == 8'h0D, "R6 second", v, 8'h0D);
        do_ack(v); chk(v == 8'h0F, "R9 spurious", v, 8'h0F);
        // R2 held-high input gives no new request, fall+rise gives one
        step(); chk(int_out == 1'b0, "R2 held", int_out, 0);
        irq[3] = 0; step(); irq[3] = 1; step();
        do_ack(v); chk(v == 8'h0B, "R2 re-edge", v, 8'h0B);
        irq = '0; step();

        // R10 mask, R1 and R3 level behaviour
        trig_we = 1; trig_wdata = 16'hFFFF; step(); trig_we = 0;
        irq[4] = 1; step();
        do_ack(v); chk(v == 8'h0C, "R3 level ack", v, 8'h0C);
        chk(int_out == 1'b1, "R3 still pending", int_out, 1);
        do_ack(v); chk(v == 8'h0C, "R3 level again", v, 8'h0C);
        irq[4] = 0; step(); chk(int_out == 1'b0, "R1 drop", int_out, 0);
        irq[1] = 1; step();
        do_ack(v); chk(v == 8'h09, "R10 line1 edge", v, 8'h09);
        do_ack(v); chk(v == 8'h0F, "R10 line1 not level", v, 8'h0F);

        // R5 rotation
        do_reset(); m_rot = 1;
        irq[0] = 1; irq[4] = 1; step();
        do_ack(v); chk(v == 8'h08, "R5 line0", v, 8'h08);
        irq[0] = 0; step(); irq[0] = 1; step();
        do_ack(v); chk(v == 8'h0C, "R5 rotated", v, 8'h0C);
        do_ack(v); chk(v == 8'h08, "R5 wrap", v, 8'h08);
        m_rot = 0;

        // R7 cascade
        do_reset();
        irq[2] = 1; step(); step(); chk(int_out == 1'b0, "R7 bit2 unused", int_out, 0);
        irq[2] = 0; irq[13] = 1; step(); step();
        chk(int_out == 1'b1, "R7 cascade int", int_out, 1);
        do_ack(v); chk(v == 8'h75, "R7 slave vec", v, 8'h75);
        step(); chk(int_out == 1'b0, "R7 cleared", int_out, 0);

        // R8 spurious slave
        irq = '0; trig_we = 1; trig_wdata = 16'h0200; step(); trig_we = 0;
        irq[9] = 1; step(); step(); irq[9] = 0; step();
        do_ack(v); chk(v == 8'h77, "R8 slave spurious", v, 8'h77);
        do_ack(v); chk(v == 8'h0F, "R8 master acked", v, 8'h0F);

        // R4 in-service blocking
        do_reset(); m_aeoi = 0;
        irq[5] = 1; step();
        do_ack(v); chk(v == 8'h0D, "R4 first", v, 8'h0D);
        irq[6] = 1; step(); step(); chk(int_out == 1'b0, "R4 lower held", int_out, 0);
        irq[1] = 1; step(); chk(int_out == 1'b1, "R4 higher", int_out, 1);
        do_ack(v); chk(v == 8'h09, "R4 nested", v, 8'h09);
        step();

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule